// File: doc/BRIEF.md
# Autobaud Low-Pulse Width Meter

This block times a single low pulse on a serial receive line, counting in cycles of the UART clock. Software arms it, a remote sender transmits a character whose first low stretch has a known length in bit times, and the measured cycle count lets software work out the sender's bit rate. The receive line is asynchronous to the clock and is brought in through a two-flop synchroniser before edges are detected. The synchroniser delays the falling edge and the rising edge by the same amount, so the delay does not change the measured width.

The unit has three states: never used, ready and measuring. It leaves the never-used state the first time software either enables the completion interrupt or arms a measurement. An armed unit waits for a falling edge and then counts until the next rising edge. When the measurement ends, the result register is loaded, the arm bit clears itself and, if the interrupt is enabled, a sticky interrupt flag is set. While a measurement runs, the visible result still holds the previous measurement. If software clears the arm bit during a measurement, the measurement is abandoned.

Top module: `abr_meter`

## Requirements
- R1: The status output encodes 0 = never used, 1 = ready, 2 = measuring, and never shows 3. After reset the status is 0, and the result, the interrupt flag and the arm bit are all 0.
- R2: The status leaves 0 for 1 at the first clock edge where irq_en_i is high or an arm write (start_we_i with start_val_i = 1) is presented. Until then it stays 0, whatever happens on rx_i.
- R3: An arm write sets start_o. A falling edge on rx_i, once synchronised, switches an armed, ready unit to measuring at the third rising clock edge after rx_i goes low. A falling edge while the unit is not armed is ignored.
- R4: A low pulse held for L clock cycles on rx_i produces a result equal to L.
- R5: While the status is 2, count_o keeps the result of the previous measurement.
- R6: At the synchronised rising edge, the status returns to 1, start_o clears and count_o takes the new measurement. This happens at the third rising clock edge after rx_i goes high.
- R7: When a measurement completes, irq_o is set only if irq_en_i is high in that cycle. Once set, irq_o stays set.
- R8: A cycle with irq_clr_i high clears irq_o. If a completion with the interrupt enabled occurs in the same cycle, the set takes priority.
- R9: A write with start_val_i = 0 during a measurement aborts it. The status goes to 1, start_o clears, count_o is unchanged and irq_o is not set. This also holds when the rising edge arrives in the same cycle.
- R10: The measurement saturates at 2^CNT_W-1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| irq_en_i | input | 1 | Completion interrupt enable (level) |
| start_we_i | input | 1 | Strobe that writes start_val_i to the arm bit |
| start_val_i | input | 1 | Value written to the arm bit: 1 arms, 0 stops |
| irq_clr_i | input | 1 | Write-one-to-clear for irq_o |
| status_o | output | 2 | State: 0 never used, 1 ready, 2 measuring |
| count_o | output | CNT_W | Last completed measurement in clock cycles |
| irq_o | output | 1 | Sticky completion interrupt flag |
| start_o | output | 1 | Arm bit; clears itself at completion or abort |

## Verification
The assertions check several rules on every cycle: the status encoding is legal, the never-used state is left only when enabled or armed, the result holds steady throughout a measurement, the arm bit is low after every return to ready, the interrupt cannot rise without the enable, and it cannot survive a clear. Other behaviour shows only in the bench's scenarios, because it depends on the timing of rx_i. These are the exact pulse-width-to-count relation, including a one-cycle pulse and saturation, the three-cycle entry latency through the synchroniser, edges ignored when the unit is not armed, an abort that leaves the result unchanged, and a set winning over a simultaneous clear.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [1:0] {
    ABR_UNUSED  = 2'd0,
    ABR_READY   = 2'd1,
    ABR_MEASURE = 2'd2
  } abr_state_e;
endpackage

// File: rtl/abr_sync.sv
module abr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic         last_q;

  // chain stage 0 samples the pin, later stages only follow
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= rx_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[TOP];
  end

  assign fall_o = last_q & ~chain_q[TOP];
  assign rise_o = ~last_q & chain_q[TOP];
endmodule

// File: rtl/abr_counter.sv
module abr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q;

  assign next_o = (cnt_q == MAXV) ? cnt_q : cnt_q + 1'b1;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= next_o;
  end
endmodule

// File: rtl/abr_ctrl.sv
module abr_ctrl
  import abr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         irq_en_i,
  input  logic         start_we_i,
  input  logic         start_val_i,
  input  logic         irq_clr_i,
  input  logic [W-1:0] cnt_next_i,
  output logic         clear_o,
  output logic         inc_o,
  output abr_state_e   state_o,
  output logic [W-1:0] result_o,
  output logic         irq_o,
  output logic         start_o
);
  abr_state_e   st_q, st_n;
  logic [W-1:0] res_q, res_n;
  logic         irq_q, irq_n;
  logic         arm_q, arm_n;
  logic         arm_req, stop_req;

  assign arm_req  = start_we_i & start_val_i;
  assign stop_req = start_we_i & ~start_val_i;

  always_comb begin
    st_n  = st_q;
    res_n = res_q;
    arm_n = arm_q;
    irq_n = irq_q & ~irq_clr_i;
    unique case (st_q)
      ABR_UNUSED: begin
        if (irq_en_i || arm_req) st_n = ABR_READY;
        if (arm_req)             arm_n = 1'b1;
      end
      ABR_READY: begin
        if (arm_req)                 arm_n = 1'b1;
        else if (stop_req)           arm_n = 1'b0;
        else if (arm_q && fall_i)    st_n  = ABR_MEASURE;
      end
      ABR_MEASURE: begin
        if (stop_req) begin
          st_n  = ABR_READY;
          arm_n = 1'b0;
        end else if (rise_i) begin
          st_n  = ABR_READY;
          arm_n = 1'b0;
          res_n = cnt_next_i;
          if (irq_en_i) irq_n = 1'b1;
        end
      end
      default: st_n = ABR_UNUSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ABR_UNUSED;
      res_q <= '0;
      irq_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      res_q <= res_n;
      irq_q <= irq_n;
      arm_q <= arm_n;
    end
  end

  assign clear_o  = (st_q != ABR_MEASURE) && (st_n == ABR_MEASURE);
  assign inc_o    = (st_q == ABR_MEASURE);
  assign state_o  = st_q;
  assign result_o = res_q;
  assign irq_o    = irq_q;
  assign start_o  = arm_q;
endmodule

// File: rtl/abr_meter.sv
module abr_meter
  import abr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             irq_en_i,
  input  logic             start_we_i,
  input  logic             start_val_i,
  input  logic             irq_clr_i,
  output logic [1:0]       status_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             start_o
);
  logic             fall, rise, clr, inc;
  logic [CNT_W-1:0] cnt_live, cnt_next;
  abr_state_e       st;

  abr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_i(rx_i), .fall_o(fall), .rise_o(rise)
  );

  abr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(clr), .inc_i(inc),
    .cnt_o(cnt_live), .next_o(cnt_next)
  );

  abr_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .fall_i(fall), .rise_i(rise),
    .irq_en_i(irq_en_i), .start_we_i(start_we_i), .start_val_i(start_val_i),
    .irq_clr_i(irq_clr_i), .cnt_next_i(cnt_next), .clear_o(clr), .inc_o(inc),
    .state_o(st), .result_o(count_o), .irq_o(irq_o), .start_o(start_o)
  );

  assign status_o = st;

  logic unused_live;
  assign unused_live = ^cnt_live;
endmodule

// File: rtl/abr_meter_chk.sv
module abr_meter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_en_i,
  input logic             start_we_i,
  input logic             start_val_i,
  input logic             irq_clr_i,
  input logic [1:0]       status_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             start_o
);
  assert_status_legal_R1: assert property (@(posedge clk) disable iff (rst)
    status_o != 2'd3);

  assert_unused_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd0 && !irq_en_i && !(start_we_i && start_val_i)) |=> status_o == 2'd0);

  assert_result_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (status_o == 2'd2) |-> $stable(count_o));

  assert_start_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o) == 2'd2 && status_o == 2'd1) |-> !start_o);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (!irq_en_i && !irq_o) |=> !irq_o);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_clr_i && status_o != 2'd2) |=> !irq_o);
endmodule

bind abr_meter abr_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq_en_i(irq_en_i), .start_we_i(start_we_i),
  .start_val_i(start_val_i), .irq_clr_i(irq_clr_i), .status_o(status_o),
  .count_o(count_o), .irq_o(irq_o), .start_o(start_o)
);

// File: tb/abr_meter_bench.sv
module abr_meter_bench;
  localparam int CW = 6;
  localparam int NV = 8;
  localparam int VWID [NV] = '{1, 2, 5, 17, 40, 63, 64, 90};
  localparam bit VIEN [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int VEXP [NV] = '{1, 2, 5, 17, 40, 63, 63, 63};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1, irq_en = 1'b0, swe = 1'b0, sval = 1'b0, iclr = 1'b0;
  logic [1:0]    status;
  logic [CW-1:0] count;
  logic          irq, start;

  int checks = 0;
  int fails  = 0;
  int prev   = 0;

  always #10 clk = ~clk;

  abr_meter #(.CNT_W(CW)) u_abr_meter (
    .clk(clk), .rst(rst), .rx_i(rx), .irq_en_i(irq_en), .start_we_i(swe),
    .start_val_i(sval), .irq_clr_i(iclr), .status_o(status), .count_o(count),
    .irq_o(irq), .start_o(start)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_start(input logic v);
    @(negedge clk); swe = 1'b1; sval = v;
    @(negedge clk); swe = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); iclr = 1'b1;
    @(negedge clk); iclr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", start, 0);

    // R2: rx activity alone keeps the unit unused
    @(negedge clk); rx = 1'b0;
    repeat (6) @(negedge clk);
    rx = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 unused kept", status, 0);

    // R2: enabling the interrupt leaves the unused state
    irq_en = 1'b1;
    @(negedge clk); irq_en = 1'b0;
    chk("R2 ready after enable", status, 1);
    chk("R2 no arm", start, 0);

    // vector loop: R3 R4 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      irq_en = VIEN[v];
      wr_start(1'b1);
      chk("R3 armed", start, 1);
      rx = 1'b0;
      for (int i = 1; i <= VWID[v]; i++) begin
        @(negedge clk);
        if (VWID[v] >= 4 && i == 2) chk("R3 not yet measuring", status, 1);
        if (VWID[v] >= 4 && i == 3) begin
          chk("R3 measuring", status, 2);
          chk("R5 result frozen", count, prev);
        end
      end
      rx = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 ready", status, 1);
      chk("R6 start cleared", start, 0);
      chk("R4 R10 result", count, VEXP[v]);
      chk("R7 irq", irq, int'(VIEN[v]));
      prev = VEXP[v];
      irq_en = 1'b0;
      pulse_irq_clr();
      chk("R8 irq cleared", irq, 0);
    end

    // R3: falling edge while not armed is ignored
    @(negedge clk); rx = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 unarmed ignored", status, 1);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 unarmed count", count, prev);

    // R9: abort mid-measurement
    irq_en = 1'b1;
    wr_start(1'b1);
    rx = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 measuring before abort", status, 2);
    wr_start(1'b0);
    chk("R9 ready", status, 1);
    chk("R9 start cleared", start, 0);
    chk("R9 count unchanged", count, prev);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 count after rise", count, prev);
    chk("R9 no irq", irq, 0);

    // R8: set wins over a clear in the same cycle
    wr_start(1'b1);
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    @(negedge clk);
    @(negedge clk); iclr = 1'b1;
    @(negedge clk); iclr = 1'b0;
    chk("R8 set wins", irq, 1);
    chk("R4 five cycles", count, 5);
    irq_en = 1'b0;
    pulse_irq_clr();
    chk("R8 cleared after", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule